// File: doc/BRIEF.md
# Flash Chip-Erase Sequencer

This block sits on the host side of a byte-wide parallel flash bus and runs a complete chip erase without software involvement. A one-cycle start pulse makes it issue the erase command, which is two write cycles that both carry the byte 30H. The erase begins inside the device at the rising edge of the second write strobe. After that edge the block polls the device with status read cycles. Completion is recognised only when bit 7 of a status byte reads 1 and bit 6 holds the same value it had on the previous status read. When completion is seen, the block pulses `done_o` and returns to idle. The device is then already in read mode, so no further command write is issued.

Each bus cycle holds its write or read strobe low for `STROBE_CLKS` clocks, then leaves all strobes high for `GAP_CLKS` clocks. If the device has not finished after `POLL_LIMIT` status reads, the block pulses `err_o` instead and returns to idle. No data stream crosses this block, so it has no valid/ready handshake. Every pin is a plain control or bus line. A start pulse that arrives while `busy_o` is high is dropped, not queued, so there is no back-pressure to honour.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, chip enable, write enable and output enable are all high, the data bus is not driven (`fl_dq_oe_o` low), and `busy_o`, `done_o` and `err_o` are low.
- R2: A start pulse produces exactly two write cycles, in order, each with data 30H at address 0.
- R3: Every write or read strobe stays low for exactly `STROBE_CLKS` clocks. Chip enable is low only while a strobe is low. At least `GAP_CLKS` clocks with chip enable high separate consecutive bus cycles. The data bus is driven only during a write strobe.
- R4: No read cycle begins before the write strobe of the second command write has returned high.
- R5: Status bits are sampled on the last clock of each read strobe. The erase counts as complete on the first status read with bit 7 = 1 whose bit 6 equals bit 6 of the read just before it. The first status read after the command can never complete the erase.
- R6: A status read with bit 7 = 1 whose bit 6 differs from the previous read does not complete the erase, and polling continues.
- R7: `done_o` is a single-cycle pulse. `busy_o` falls on the same clock edge, and no bus cycle follows completion.
- R8: If `POLL_LIMIT` status reads pass without completion, `err_o` pulses for one cycle, `busy_o` falls and the block goes idle. A completion found on read number `POLL_LIMIT` is still reported as done. `done_o` and `err_o` are never high together.
- R9: `busy_o` rises on the clock after a start pulse and stays high until the done or error pulse. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a chip erase |
| busy_o | output | 1 | High from the clock after start until done or error |
| done_o | output | 1 | One-cycle pulse when the erase has completed |
| err_o | output | 1 | One-cycle pulse when the poll limit is reached |
| fl_ce_n_o | output | 1 | Flash chip enable, active low |
| fl_we_n_o | output | 1 | Flash write strobe, active low |
| fl_oe_n_o | output | 1 | Flash read strobe, active low |
| fl_addr_o | output | ADDR_W | Flash address |
| fl_dq_o | output | 8 | Data driven to the flash during writes |
| fl_dq_oe_o | output | 1 | High while `fl_dq_o` should drive the bus |
| fl_dq_i | input | 8 | Data read back from the flash |

## Verification
The bench builds the block with `STROBE_CLKS` = 3, `GAP_CLKS` = 2 and `POLL_LIMIT` = 20. With these values, multi-clock strobe widths and multi-clock gaps are both measured rather than being trivially one clock. The small poll limit lets a device that never finishes reach the error path in a few hundred clocks. It also puts completion exactly on read 20 (done) and on read 21 (error) within reach. A behavioural flash model toggles bit 6 while it is erasing and can raise bit 7 one read early while bit 6 is still moving. Randomly chosen erase lengths and final bit-6 levels are mixed with those directed edges.

// File: rtl/fes_pkg.sv
package fes_pkg;

  localparam int unsigned DQ_W       = 8;
  localparam int unsigned READY_BIT  = 7;
  localparam int unsigned TOGGLE_BIT = 6;
  localparam logic [DQ_W-1:0] ERASE_CMD = 8'h30;

  typedef enum logic [1:0] {
    BC_IDLE,
    BC_STRB,
    BC_GAP
  } bc_state_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CMD1,
    SQ_CMD2,
    SQ_POLL
  } sq_state_t;

endpackage

// File: rtl/fes_bus_cycle.sv
module fes_bus_cycle
  import fes_pkg::*;
#(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned STROBE_CLKS = 3,
  parameter int unsigned GAP_CLKS    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_data,
  output logic              cyc_done,
  output logic [DQ_W-1:0]   rd_data,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe,
  input  logic [DQ_W-1:0]   dq_i
);

  localparam int unsigned MAXC = (STROBE_CLKS > GAP_CLKS) ? STROBE_CLKS : GAP_CLKS;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] STRB_LAST = CW'(STROBE_CLKS - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_CLKS - 1);

  bc_state_t         st_q;
  logic [CW-1:0]     cnt_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   data_q;
  logic [DQ_W-1:0]   rd_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= BC_IDLE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        BC_IDLE: begin
          if (req_valid) begin
            st_q   <= BC_STRB;
            cnt_q  <= '0;
            wr_q   <= req_wr;
            addr_q <= req_addr;
            data_q <= req_data;
          end
        end
        BC_STRB: begin
          if (cnt_q == STRB_LAST) begin
            if (!wr_q) rd_q <= dq_i;
            st_q  <= BC_GAP;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        BC_GAP: begin
          if (cnt_q == GAP_LAST) begin
            st_q   <= BC_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= BC_IDLE;
      endcase
    end
  end

  logic strobing;
  assign strobing  = (st_q == BC_STRB);
  assign req_ready = (st_q == BC_IDLE);
  assign cyc_done  = done_q;
  assign rd_data   = rd_q;
  assign ce_n      = !strobing;
  assign we_n      = !(strobing && wr_q);
  assign oe_n      = !(strobing && !wr_q);
  assign addr      = addr_q;
  assign dq_o      = data_q;
  assign dq_oe     = strobing && wr_q;

  // R3: never both strobes at once
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));
  // R3: chip enable tracks the strobes
  p_ce_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n == (we_n && oe_n));
  // R3: bus driven only under a write strobe
  p_drive_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);
  // R3: address held for the whole strobe
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> $stable(addr));
  // R3: a strobe is followed by a gap, never directly by another strobe
  p_gap_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |=> ce_n);

endmodule

// File: rtl/fes_poll_eval.sv
module fes_poll_eval
  import fes_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            rd_valid,
  input  logic [DQ_W-1:0] rd_data,
  output logic            complete
);

  logic have_prev_q;
  logic prev_tog_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      prev_tog_q  <= 1'b0;
    end else if (clr) begin
      have_prev_q <= 1'b0;
    end else if (rd_valid) begin
      have_prev_q <= 1'b1;
      prev_tog_q  <= rd_data[TOGGLE_BIT];
    end
  end

  assign complete = rd_valid && have_prev_q && rd_data[READY_BIT]
                    && (rd_data[TOGGLE_BIT] == prev_tog_q);

  // R5: the first read after a clear can never complete
  p_first_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !have_prev_q) |-> !complete);
  // R6: a moving toggle bit blocks completion
  p_toggle_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && have_prev_q && rd_data[TOGGLE_BIT] != prev_tog_q) |-> !complete);

endmodule

// File: rtl/fes_poll_limit.sv
module fes_poll_limit #(
  parameter int unsigned POLL_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic expired
);

  localparam int unsigned LW = $clog2(POLL_LIMIT + 1);
  localparam logic [LW-1:0] LAST = LW'(POLL_LIMIT - 1);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign expired = tick && (cnt_q == LAST);

  // R8: the read counter never passes the limit
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned STROBE_CLKS = 3,
  parameter int unsigned GAP_CLKS    = 1,
  parameter int unsigned POLL_LIMIT  = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              fl_ce_n_o,
  output logic              fl_we_n_o,
  output logic              fl_oe_n_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [DQ_W-1:0]   fl_dq_o,
  output logic              fl_dq_oe_o,
  input  logic [DQ_W-1:0]   fl_dq_i
);

  localparam logic [ADDR_W-1:0] CMD_ADDR = '0;

  sq_state_t       sq_q;
  logic            pend_q, busy_q, done_q, err_q;
  logic            req_ready, cyc_done;
  logic [DQ_W-1:0] rd_data;
  logic            poll_clr, rd_valid, complete, expired;

  assign poll_clr = (sq_q == SQ_CMD2) && cyc_done;
  assign rd_valid = (sq_q == SQ_POLL) && cyc_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_q   <= SQ_IDLE;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (pend_q && req_ready) pend_q <= 1'b0;
      unique case (sq_q)
        SQ_IDLE: if (start_i) begin
          sq_q   <= SQ_CMD1;
          busy_q <= 1'b1;
          pend_q <= 1'b1;
        end
        SQ_CMD1: if (cyc_done) begin
          sq_q   <= SQ_CMD2;
          pend_q <= 1'b1;
        end
        SQ_CMD2: if (cyc_done) begin
          sq_q   <= SQ_POLL;
          pend_q <= 1'b1;
        end
        SQ_POLL: if (cyc_done) begin
          if (complete) begin
            done_q <= 1'b1;
            busy_q <= 1'b0;
            sq_q   <= SQ_IDLE;
          end else if (expired) begin
            err_q  <= 1'b1;
            busy_q <= 1'b0;
            sq_q   <= SQ_IDLE;
          end else begin
            pend_q <= 1'b1;
          end
        end
        default: sq_q <= SQ_IDLE;
      endcase
    end
  end

  fes_bus_cycle #(
    .ADDR_W      (ADDR_W),
    .STROBE_CLKS (STROBE_CLKS),
    .GAP_CLKS    (GAP_CLKS)
  ) u_cycle (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (pend_q),
    .req_ready (req_ready),
    .req_wr    (sq_q != SQ_POLL),
    .req_addr  (CMD_ADDR),
    .req_data  (ERASE_CMD),
    .cyc_done  (cyc_done),
    .rd_data   (rd_data),
    .ce_n      (fl_ce_n_o),
    .we_n      (fl_we_n_o),
    .oe_n      (fl_oe_n_o),
    .addr      (fl_addr_o),
    .dq_o      (fl_dq_o),
    .dq_oe     (fl_dq_oe_o),
    .dq_i      (fl_dq_i)
  );

  fes_poll_eval u_eval (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (poll_clr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .complete (complete)
  );

  fes_poll_limit #(.POLL_LIMIT(POLL_LIMIT)) u_limit (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (poll_clr),
    .tick    (rd_valid),
    .expired (expired)
  );

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7: bus quiet whenever not busy
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> fl_ce_n_o);
  // R8: error lasts one cycle and never meets done
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  // R9: busy rises only after a start pulse
  p_busy_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  // R9: busy falls only with done or error
  p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o || err_o));
  // R4: read strobes only while polling
  p_read_in_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n_o |-> (sq_q == SQ_POLL));

endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;

  localparam int AW = 18;
  localparam int SC = 3;
  localparam int GC = 2;
  localparam int PL = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, err;
  logic          ce_n, we_n, oe_n, dq_oe;
  logic [AW-1:0] addr;
  logic [7:0]    dq_o, dq_i;

  always #10 clk = ~clk;

  flash_erase_seq #(.ADDR_W(AW), .STROBE_CLKS(SC), .GAP_CLKS(GAP_OK), .POLL_LIMIT(PL)) u_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done), .err_o(err),
    .fl_ce_n_o(ce_n), .fl_we_n_o(we_n), .fl_oe_n_o(oe_n), .fl_addr_o(addr),
    .fl_dq_o(dq_o), .fl_dq_oe_o(dq_oe), .fl_dq_i(dq_i)
  );
  localparam int GAP_OK = GC;

  int total = 0, bad = 0;
  int m_busy = 0; bit m_v = 0; bit m_early = 0;
  int rd_cnt, wr_cnt, wr_bad, strobe_bad, gap_bad, rd_early, done_cnt, err_cnt, wide_bad, quiet_bad;
  int we_len, oe_len, gap_len; bit seen_cyc;
  logic we_p = 1, oe_p = 1, ce_p = 1, done_p = 0, err_p = 0;

  // Device status byte for read k (1-based): bit7 ready, bit6 toggles while erasing
  function automatic logic [7:0] dev_status(int k, int b, bit v, bit early);
    logic [7:0] s;
    s = 8'(k) & 8'h3f;
    s[7] = (k > b) || (early && k == b);
    s[6] = (k <= b) ? k[0] : v;
    return s;
  endfunction

  // Expected read count at completion, or -1 when the limit is hit first
  function automatic int exp_reads(int b, bit v, bit early);
    logic [7:0] s; bit prev = 0;
    for (int k = 1; k <= PL; k++) begin
      s = dev_status(k, b, v, early);
      if (k > 1 && s[7] && s[6] == prev) return k;
      prev = s[6];
    end
    return -1;
  endfunction

  assign dq_i = dev_status(rd_cnt + 1, m_busy, m_v, m_early);

  task automatic clear_mon();
    rd_cnt = 0; wr_cnt = 0; wr_bad = 0; strobe_bad = 0; gap_bad = 0; rd_early = 0;
    done_cnt = 0; err_cnt = 0; wide_bad = 0; quiet_bad = 0;
    we_len = 0; oe_len = 0; gap_len = 0; seen_cyc = 0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (!we_n) begin
      we_len++;
      if (!dq_oe || dq_o !== 8'h30 || addr !== '0) wr_bad++;
    end else if (!we_p) begin
      if (we_len != SC) strobe_bad++;
      wr_cnt++; we_len = 0;
    end
    if (!oe_n) begin
      if (oe_p && wr_cnt < 2) rd_early++;
      if (dq_oe) wr_bad++;
      oe_len++;
    end else if (!oe_p) begin
      if (oe_len != SC) strobe_bad++;
      rd_cnt++; oe_len = 0;
    end
    if (ce_n == (!we_n || !oe_n)) strobe_bad++;
    if (ce_n) gap_len++;
    else if (ce_p) begin
      if (seen_cyc && gap_len < GC) gap_bad++;
      gap_len = 0; seen_cyc = 1;
    end
    if (!ce_n && !busy) quiet_bad++;
    if (done) begin done_cnt++; if (done_p || busy) wide_bad++; end
    if (err) begin err_cnt++; if (err_p || busy) wide_bad++; end
    we_p = we_n; oe_p = oe_n; ce_p = ce_n; done_p = done; err_p = err;
  end

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_case(int b, bit v, bit early, bit dbl);
    int e, guard;
    string tag;
    m_busy = b; m_v = v; m_early = early;
    clear_mon();
    e = exp_reads(b, v, early);
    tag = (e < 0) ? "R8" : (early ? "R6" : "R5");
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R9 busy after start", int'(busy), 1);
    if (dbl) begin
      repeat (5) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (done_cnt + err_cnt == 0 && guard < 5000) begin @(negedge clk); guard++; end
    repeat (12) @(negedge clk);
    if (e > 0) begin
      chk(done_cnt == 1, {tag, " done pulses"}, done_cnt, 1);
      chk(err_cnt == 0, "R8 no error", err_cnt, 0);
      chk(rd_cnt == e, {tag, " read count"}, rd_cnt, e);
    end else begin
      chk(err_cnt == 1, "R8 error pulses", err_cnt, 1);
      chk(done_cnt == 0, "R8 no done", done_cnt, 0);
      chk(rd_cnt == PL, "R8 read count", rd_cnt, PL);
    end
    chk(wr_cnt == 2, dbl ? "R9 ignored restart writes" : "R2 write count", wr_cnt, 2);
    chk(wr_bad == 0, "R2 write data/address", wr_bad, 0);
    chk(strobe_bad == 0, "R3 strobe width", strobe_bad, 0);
    chk(gap_bad == 0, "R3 gap", gap_bad, 0);
    chk(rd_early == 0, "R4 read before erase", rd_early, 0);
    chk(wide_bad == 0, "R7 pulse width/busy", wide_bad, 0);
    chk(quiet_bad == 0, "R7 bus quiet when idle", quiet_bad, 0);
    chk(busy === 1'b0, "R9 busy after finish", int'(busy), 0);
  endtask

  initial begin
    int b; bit v, ea;
    void'($urandom(32'd4321));
    repeat (4) @(negedge clk);
    chk(ce_n === 1 && we_n === 1 && oe_n === 1, "R1 strobes high", int'({ce_n, we_n, oe_n}), 7);
    chk(dq_oe === 0, "R1 bus released", int'(dq_oe), 0);
    chk(busy === 0 && done === 0 && err === 0, "R1 status low", int'({busy, done, err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case(0, 0, 0, 0);    // R5 first read cannot finish
    run_case(4, 0, 0, 0);    // R5
    run_case(4, 1, 0, 0);    // R5
    run_case(5, 0, 1, 0);    // R6 ready bit early, toggle still moving
    run_case(19, 1, 0, 0);   // R8 completes on the last allowed read
    run_case(19, 0, 0, 0);   // R8 one read too many
    run_case(1000, 0, 0, 1); // R8 never finishes, R9 restart ignored
    run_case(3, 1, 0, 1);    // R9 restart ignored
    for (int i = 0; i < 12; i++) begin
      b = $urandom_range(0, 24); v = 1'($urandom); ea = 1'($urandom);
      run_case(b, v, ea, 1'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule